// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Walker

This block runs one DMA channel over a circular ring of 16-byte descriptors held in memory. Software sets the ring's start address and the number of descriptors, then raises a start bit. From then on, software hands descriptors to the channel by moving a tail pointer forward. The tail pointer holds the address one slot past the last descriptor that is ready.

The channel keeps a current-descriptor index. While that index differs from the tail index, the channel issues one fetch request per descriptor, and each request carries the descriptor's address. An accepted request advances the index. After the last slot of the ring, the index wraps back to the start address. When the index reaches the tail, the channel suspends and emits a one-cycle pulse. It resumes when software moves the tail away from the current position.

The fetch request is a valid/ready stream. `fetch_valid` stays high and `fetch_addr` stays stable until the consumer asserts `fetch_ready` in the same cycle. The consumer may hold `fetch_ready` low for any number of cycles, and the channel never has more than one request open. Register access uses a plain write strobe and a combinational read mux.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, the channel state is stopped (encoding 0), `fetch_valid` and `suspend_pulse` are low, and the current-pointer readback (register index 4) returns 0.
- R2: While the channel is stopped, a write to the ring start register (index 1) or the slot-count register (index 2) rewinds the current pointer to the ring start. In the running or suspended state, writes to these two registers are ignored.
- R3: Writing 1 to bit 0 of the control register (index 0) moves a stopped channel to running (encoding 1). Each fetch address is start + index × 16.
- R4: A request that has not been accepted keeps `fetch_valid` high and `fetch_addr` unchanged. The current pointer advances only in a cycle where `fetch_valid` and `fetch_ready` are both high.
- R5: When the current index equals the tail index and no request is open, the channel enters suspended (encoding 2). `suspend_pulse` is high for exactly the first cycle of that state.
- R6: A tail write (register index 3) that leaves the tail equal to the current pointer keeps the channel suspended with no request. A tail write that moves the tail elsewhere restarts fetching.
- R7: The slot-count register holds the number of descriptors minus one. After the slot at that index, the next fetch goes to the ring start.
- R8: The tail is compared as a ring-relative index. A tail numerically below the current pointer makes the channel fetch up to the ring end and then from the start up to the slot before the tail. A tail equal to start + (count+1) × 16 means index 0.
- R9: Clearing the start bit stops the channel (encoding 0) one cycle after any open request is accepted. No new request is issued after that.
- R10: Readback returns the start bit (index 0), ring start (1), slot count (2), tail address (3) and current descriptor address (4), all on the same cycle as the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| fetch_valid | output | 1 | Descriptor fetch request valid |
| fetch_ready | input | 1 | Descriptor fetch request accepted |
| fetch_addr | output | ADDR_W | Address of the descriptor to fetch |
| chan_state | output | 2 | 0 stopped, 1 running, 2 suspended |
| suspend_pulse | output | 1 | One-cycle pulse on entry into suspended |

## Verification
A register write takes effect at the edge where it is strobed, and its readback is exact on the following sample. After the start bit is set, the first request appears two edges later: one edge moves the channel to running and the next opens the request. After an acceptance, suspension and its pulse are due exactly one edge after the edge that closes the request, and a stop is due at that same point. Every check samples 1 ns after a rising edge. Request arrival is polled within a bounded window. Suspend, pulse and stop timing are checked at their exact cycle, and the cycle after is checked as well.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

  typedef enum logic [1:0] {
    CH_STOPPED   = 2'd0,
    CH_RUNNING   = 2'd1,
    CH_SUSPENDED = 2'd2
  } ch_state_e;

  localparam logic [2:0] RIX_CTRL = 3'd0;
  localparam logic [2:0] RIX_BASE = 3'd1;
  localparam logic [2:0] RIX_LEN  = 3'd2;
  localparam logic [2:0] RIX_TAIL = 3'd3;
  localparam logic [2:0] RIX_CUR  = 3'd4;

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
  import ring_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              chan_stopped,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              start,
  output logic [ADDR_W-1:0] ring_base,
  output logic [LEN_W-1:0]  ring_len,
  output logic [ADDR_W-1:0] tail_addr,
  output logic              rewind,
  output logic [ADDR_W-1:0] reg_rdata
);

  localparam int PAD_LEN = ADDR_W - LEN_W;

  // ring geometry is writable only while the channel is idle
  logic geom_wr_ok;
  assign geom_wr_ok = reg_wr && chan_stopped;
  assign rewind     = geom_wr_ok && (reg_addr == RIX_BASE || reg_addr == RIX_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start     <= 1'b0;
      ring_base <= '0;
      ring_len  <= '0;
      tail_addr <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RIX_CTRL: start <= reg_wdata[0];
        RIX_BASE: if (geom_wr_ok) ring_base <= reg_wdata;
        RIX_LEN:  if (geom_wr_ok) ring_len  <= reg_wdata[LEN_W-1:0];
        RIX_TAIL: tail_addr <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RIX_CTRL: reg_rdata = {{(ADDR_W-1){1'b0}}, start};
      RIX_BASE: reg_rdata = ring_base;
      RIX_LEN:  reg_rdata = {{PAD_LEN{1'b0}}, ring_len};
      RIX_TAIL: reg_rdata = tail_addr;
      RIX_CUR:  reg_rdata = cur_addr;
      default:  reg_rdata = '0;
    endcase
  end

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_stopped |=> $stable(ring_base)); // R2
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_stopped |=> $stable(ring_len)); // R2

endmodule

// File: rtl/ring_idx_math.sv
module ring_idx_math #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int DESC_SHIFT = 4
) (
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LEN_W-1:0]  ring_len,
  input  logic [ADDR_W-1:0] tail_addr,
  input  logic [LEN_W-1:0]  cur_idx,
  output logic [LEN_W-1:0]  tail_idx,
  output logic [LEN_W-1:0]  next_idx,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int IDX_W = ADDR_W - DESC_SHIFT;

  logic [IDX_W-1:0] tail_raw;
  logic [IDX_W-1:0] len_ext;

  // slot offset of the tail measured from the ring start
  assign tail_raw = IDX_W'((tail_addr - ring_base) >> DESC_SHIFT);
  assign len_ext  = IDX_W'(ring_len);

  // one past the final slot is the same position as slot zero
  assign tail_idx = (tail_raw > len_ext) ? '0 : tail_raw[LEN_W-1:0];

  assign next_idx = (cur_idx == ring_len) ? '0 : cur_idx + LEN_W'(1);

  assign cur_addr = ring_base + (ADDR_W'(cur_idx) << DESC_SHIFT);

endmodule

// File: rtl/ring_walk_ctl.sv
module ring_walk_ctl
  import ring_walk_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rewind,
  input  logic [LEN_W-1:0] ring_len,
  input  logic [LEN_W-1:0] tail_idx,
  input  logic [LEN_W-1:0] next_idx,
  input  logic             fetch_ready,
  output logic             fetch_valid,
  output logic [LEN_W-1:0] cur_idx,
  output ch_state_e        state,
  output logic             suspend_pulse
);

  logic req_open;
  logic req_ack;
  logic at_tail;

  assign fetch_valid = req_open;
  assign req_ack     = req_open && fetch_ready;
  assign at_tail     = (cur_idx == tail_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= CH_STOPPED;
      req_open      <= 1'b0;
      cur_idx       <= '0;
      suspend_pulse <= 1'b0;
    end else begin
      suspend_pulse <= 1'b0;

      if (req_ack)     cur_idx <= next_idx;
      else if (rewind) cur_idx <= '0;

      case (state)
        CH_STOPPED: begin
          if (start) state <= CH_RUNNING;
        end
        CH_RUNNING: begin
          if (req_open) begin
            if (req_ack) req_open <= 1'b0;
          end else if (!start) begin
            state <= CH_STOPPED;
          end else if (at_tail) begin
            state         <= CH_SUSPENDED;
            suspend_pulse <= 1'b1;
          end else begin
            req_open <= 1'b1;
          end
        end
        CH_SUSPENDED: begin
          if (!start)       state <= CH_STOPPED;
          else if (!at_tail) state <= CH_RUNNING;
        end
        default: state <= CH_STOPPED;
      endcase
    end
  end

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(cur_idx)); // R4
  AST_STEP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ack && !rewind |=> $stable(cur_idx)); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    state != CH_RUNNING |-> !fetch_valid); // R9
  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_pulse |-> state == CH_SUSPENDED && $past(state) == CH_RUNNING); // R5
  AST_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    state == CH_RUNNING |-> cur_idx <= ring_len); // R7

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
  import ring_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 10,
  parameter int DESC_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        chan_state,
  output logic              suspend_pulse
);

  logic              start;
  logic              rewind;
  logic [ADDR_W-1:0] ring_base;
  logic [LEN_W-1:0]  ring_len;
  logic [ADDR_W-1:0] tail_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  cur_idx;
  logic [LEN_W-1:0]  tail_idx;
  logic [LEN_W-1:0]  next_idx;
  ch_state_e         state;

  ring_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .chan_stopped (state == CH_STOPPED),
    .cur_addr     (cur_addr),
    .start        (start),
    .ring_base    (ring_base),
    .ring_len     (ring_len),
    .tail_addr    (tail_addr),
    .rewind       (rewind),
    .reg_rdata    (reg_rdata)
  );

  ring_idx_math #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_SHIFT(DESC_SHIFT)) u_math (
    .ring_base (ring_base),
    .ring_len  (ring_len),
    .tail_addr (tail_addr),
    .cur_idx   (cur_idx),
    .tail_idx  (tail_idx),
    .next_idx  (next_idx),
    .cur_addr  (cur_addr)
  );

  ring_walk_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .rewind        (rewind),
    .ring_len      (ring_len),
    .tail_idx      (tail_idx),
    .next_idx      (next_idx),
    .fetch_ready   (fetch_ready),
    .fetch_valid   (fetch_valid),
    .cur_idx       (cur_idx),
    .state         (state),
    .suspend_pulse (suspend_pulse)
  );

  assign fetch_addr = cur_addr;
  assign chan_state = state;

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> $stable(fetch_addr)); // R4

endmodule

// File: tb/desc_ring_walker_bench.sv
module desc_ring_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_valid;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic [1:0]  chan_state;
  logic        suspend_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  desc_ring_walker u_desc_ring_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .fetch_addr    (fetch_addr),
    .chan_state    (chan_state),
    .suspend_pulse (suspend_pulse)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #0.5;
    chk(reg_rdata, exp, tag);
  endtask

  // wait for a request, check address, optionally stall, then accept
  task automatic take_fetch(input logic [31:0] exp, input int stall, input string tag);
    int waited = 0;
    while (!fetch_valid && waited < 30) begin
      step();
      waited++;
    end
    chk({31'd0, fetch_valid}, 32'd1, {tag, " request present"});
    chk(fetch_addr, exp, {tag, " address"});
    for (int i = 0; i < stall; i++) begin
      step();
      chk({31'd0, fetch_valid}, 32'd1, "R4 valid held");
      chk(fetch_addr, exp, "R4 address held");
    end
    fetch_ready = 1'b1;
    step();
    fetch_ready = 1'b0;
  endtask

  task automatic expect_suspend(input string tag);
    step();
    chk({30'd0, chan_state}, 32'd2, {tag, " R5 suspended"});
    chk({31'd0, suspend_pulse}, 32'd1, {tag, " R5 pulse"});
    step();
    chk({31'd0, suspend_pulse}, 32'd0, {tag, " R5 pulse one cycle"});
    chk({30'd0, chan_state}, 32'd2, {tag, " R5 stays suspended"});
  endtask

  task automatic quiet(input int n, input logic [1:0] st, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      chk({31'd0, fetch_valid}, 32'd0, {tag, " no request"});
      chk({30'd0, chan_state}, {30'd0, st}, {tag, " state"});
    end
  endtask

  task automatic t_reset();
    chk({30'd0, chan_state}, 32'd0, "R1 state");
    chk({31'd0, fetch_valid}, 32'd0, "R1 valid");
    chk({31'd0, suspend_pulse}, 32'd0, "R1 pulse");
    rd_chk(3'd4, 32'd0, "R1 current pointer");
  endtask

  task automatic t_config();
    wr(3'd1, 32'h1000);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'h1020);
    rd_chk(3'd4, 32'h1000, "R2 current loaded from start");
    rd_chk(3'd1, 32'h1000, "R10 start readback");
    rd_chk(3'd2, 32'd3, "R10 count readback");
    rd_chk(3'd3, 32'h1020, "R10 tail readback");
  endtask

  task automatic t_first_run();
    wr(3'd0, 32'd1);
    rd_chk(3'd0, 32'd1, "R10 control readback");
    step();
    chk({30'd0, chan_state}, 32'd1, "R3 running");
    take_fetch(32'h1000, 3, "R3 first");
    take_fetch(32'h1010, 0, "R3 second");
    expect_suspend("first run");
    rd_chk(3'd4, 32'h1020, "R5 current at tail");
    quiet(4, 2'd2, "R5 idle");
  endtask

  task automatic t_locked_geometry();
    wr(3'd1, 32'h5000);
    wr(3'd2, 32'd7);
    rd_chk(3'd1, 32'h1000, "R2 start write ignored");
    rd_chk(3'd2, 32'd3, "R2 count write ignored");
    rd_chk(3'd4, 32'h1020, "R2 current unchanged");
  endtask

  task automatic t_tail_wrap();
    wr(3'd3, 32'h1020);
    quiet(4, 2'd2, "R6 equal tail");
    wr(3'd3, 32'h1010);
    take_fetch(32'h1020, 0, "R8 below tail a");
    take_fetch(32'h1030, 1, "R7 last slot");
    take_fetch(32'h1000, 0, "R7 wrapped");
    expect_suspend("wrap run");
    rd_chk(3'd4, 32'h1010, "R8 current at tail");
  endtask

  task automatic t_end_tail();
    wr(3'd3, 32'h1040);
    take_fetch(32'h1010, 0, "R8 end tail a");
    take_fetch(32'h1020, 0, "R8 end tail b");
    take_fetch(32'h1030, 0, "R8 end tail c");
    expect_suspend("end tail");
    rd_chk(3'd4, 32'h1000, "R8 end tail current");
  endtask

  task automatic t_stop();
    int waited = 0;
    wr(3'd3, 32'h1020);
    while (!fetch_valid && waited < 30) begin
      step();
      waited++;
    end
    chk(fetch_addr, 32'h1000, "R9 open request address");
    wr(3'd0, 32'd0);
    chk({30'd0, chan_state}, 32'd1, "R9 running while open");
    chk({31'd0, fetch_valid}, 32'd1, "R9 request kept");
    step();
    chk({31'd0, fetch_valid}, 32'd1, "R9 request kept later");
    fetch_ready = 1'b1;
    step();
    fetch_ready = 1'b0;
    chk({30'd0, chan_state}, 32'd1, "R9 not yet stopped");
    step();
    chk({30'd0, chan_state}, 32'd0, "R9 stopped");
    quiet(4, 2'd0, "R9 after stop");
    rd_chk(3'd4, 32'h1010, "R9 current after stop");
  endtask

  task automatic t_rewind();
    wr(3'd1, 32'h2000);
    rd_chk(3'd4, 32'h2000, "R2 rewind on start write");
    wr(3'd2, 32'd1);
    rd_chk(3'd2, 32'd1, "R2 count write while stopped");
    rd_chk(3'd0, 32'd0, "R10 control cleared");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_config();
    t_first_run();
    t_locked_geometry();
    t_tail_wrap();
    t_end_tail();
    t_stop();
    t_rewind();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule